// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers interrupt requests from a multi-channel DMA engine and turns them into a single interrupt line for a host processor. The requests fall into three groups: transmit channels, receive channels and DMA error sources. Each group has its own enable mask. The host reads each group through a small 32-bit register port that uses word addresses.

The mask for a group is never written as a whole. A host enables sources by writing ones to that group's enable-set register, and disables them by writing ones to its enable-clear register. For each group the host can read the unmasked request levels and the masked view.

The interrupt line is the OR of every masked request. An end-of-interrupt write forces the line low for one cycle. If work is still pending, the line then rises again, so a host that detects edges sees a fresh edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the interrupt output is low, all three masks are zero and the read data output is zero.
- R2: Writing a word to a group's enable-set register enables every source whose bit is 1; bits written as 0 leave the mask unchanged. The enable-set byte offsets are 0x88 (transmit), 0xA8 (receive) and 0xB8 (error). The register takes effect on the clock edge of the write.
- R3: Writing a word to a group's enable-clear register disables every source whose bit is 1; bits written as 0 leave the mask unchanged. The enable-clear byte offsets are 0x8C, 0xAC and 0xBC. Writing 0xFFFFFFFF clears the whole group.
- R4: Mask bit i and status bit i belong to request input bit i. Bits above a group's width read as zero. In the error group, bit 1 is the host-error source.
- R5: The raw status registers (byte offsets 0x80, 0xA0 and 0xB0) read the request inputs as captured one clock earlier, and they follow the requests when they fall.
- R6: The masked status registers (byte offsets 0x84, 0xA4 and 0xB4) read as raw status AND mask.
- R7: The enable-set and enable-clear registers both read back the current mask.
- R8: Writes to the raw and masked status registers change no state.
- R9: The interrupt output is a registered OR of all masked bits across the three groups. It rises one clock after a masked bit becomes set and falls one clock after none remain.
- R10: A write of zero to the end-of-interrupt register (byte offset 0x94) drives the interrupt output low for the next cycle. In the cycle after that, the output is high again if any masked bit is still set. A nonzero write to that register has no effect.
- R11: Read data is registered and appears the cycle after a read strobe, and it holds until the next read. A read from an unmapped offset, including the end-of-interrupt offset, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | TX_CH | Transmit channel request levels |
| rx_req | input | RX_CH | Receive channel request levels |
| err_req | input | ERR_SRC | DMA error source levels (bit 1 host error) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt output |

## Verification
The enable masks are driven with partial set and clear patterns. These show whether zero bits are left untouched, or whether the register is simply overwritten. All-ones writes probe the width boundary of each group. Separate request patterns in the transmit, receive and error groups are read through both status views, and each one is matched against a mask that overlaps it only in part. The AND in the masked view is exposed by showing that an unmasked request never reaches the interrupt line. The end-of-interrupt write is tried three ways: with work still pending, with nothing pending, and with a nonzero value. These cases separate the one-cycle drop from a missing drop, from a stuck-low line, and from a write that is decoded too loosely.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  // Byte offsets of each group's base and of the end-of-interrupt register
  localparam int TX_BASE_B  = 'h80;
  localparam int RX_BASE_B  = 'hA0;
  localparam int ERR_BASE_B = 'hB0;
  localparam int EOI_B      = 'h94;

  // Register slot inside a group (word offset from the group base)
  typedef enum logic [1:0] {
    SLOT_RAW = 2'd0,
    SLOT_MSK = 2'd1,
    SLOT_SET = 2'd2,
    SLOT_CLR = 2'd3
  } slot_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_status_pkg::*;
#(
  parameter int                WIDTH  = 8,
  parameter int                ADDR_W = 6,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wbits,
  output logic [WIDTH-1:0]  mask,
  output logic [WIDTH-1:0]  masked,
  output logic              hit,
  output word_t             rd_word
);
  logic [WIDTH-1:0] raw_q;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic             mask_en;
  slot_e            slot;

  assign hit  = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
  assign slot = slot_e'(addr[1:0]);

  // next state of the mask: only set/clear writes touch it
  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (wr_en && hit) begin
      if (slot == SLOT_SET) begin
        mask_d  = mask_q | wbits;
        mask_en = 1'b1;
      end else if (slot == SLOT_CLR) begin
        mask_d  = mask_q & ~wbits;
        mask_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= req;
  end

  assign mask   = mask_q;
  assign masked = raw_q & mask_q;

  always_comb begin
    unique case (slot)
      SLOT_RAW: rd_word = word_t'(raw_q);
      SLOT_MSK: rd_word = word_t'(masked);
      default:  rd_word = word_t'(mask_q);
    endcase
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic eoi_wr,
  output logic irq
);
  logic irq_q, irq_d;

  // an end-of-interrupt write blanks the line for exactly one cycle
  always_comb irq_d = any_pend & ~eoi_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int TX_CH   = 8,
  parameter int RX_CH   = 8,
  parameter int ERR_SRC = 2,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TX_CH-1:0]   tx_req,
  input  logic [RX_CH-1:0]   rx_req,
  input  logic [ERR_SRC-1:0] err_req,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] TX_WA  = ADDR_W'(TX_BASE_B  >> 2);
  localparam logic [ADDR_W-1:0] RX_WA  = ADDR_W'(RX_BASE_B  >> 2);
  localparam logic [ADDR_W-1:0] ERR_WA = ADDR_W'(ERR_BASE_B >> 2);
  localparam logic [ADDR_W-1:0] EOI_WA = ADDR_W'(EOI_B      >> 2);

  logic               rst_n_s;
  logic [TX_CH-1:0]   tx_mask, tx_masked;
  logic [RX_CH-1:0]   rx_mask, rx_masked;
  logic [ERR_SRC-1:0] err_mask, err_masked;
  logic               tx_hit, rx_hit, err_hit;
  word_t              tx_word, rx_word, err_word;
  logic               any_pend, eoi_wr;
  word_t              rdata_q, rdata_d;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  irq_src_bank #(.WIDTH(TX_CH), .ADDR_W(ADDR_W), .BASE(TX_WA)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .req(tx_req), .wr_en(wr_en), .addr(addr),
    .wbits(wdata[TX_CH-1:0]), .mask(tx_mask), .masked(tx_masked),
    .hit(tx_hit), .rd_word(tx_word));

  irq_src_bank #(.WIDTH(RX_CH), .ADDR_W(ADDR_W), .BASE(RX_WA)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .req(rx_req), .wr_en(wr_en), .addr(addr),
    .wbits(wdata[RX_CH-1:0]), .mask(rx_mask), .masked(rx_masked),
    .hit(rx_hit), .rd_word(rx_word));

  irq_src_bank #(.WIDTH(ERR_SRC), .ADDR_W(ADDR_W), .BASE(ERR_WA)) u_err (
    .clk(clk), .rst_n(rst_n_s), .req(err_req), .wr_en(wr_en), .addr(addr),
    .wbits(wdata[ERR_SRC-1:0]), .mask(err_mask), .masked(err_masked),
    .hit(err_hit), .rd_word(err_word));

  assign any_pend = (|tx_masked) | (|rx_masked) | (|err_masked);
  assign eoi_wr   = wr_en && (addr == EOI_WA) && (wdata == '0);

  irq_out_stage u_out (
    .clk(clk), .rst_n(rst_n_s), .any_pend(any_pend), .eoi_wr(eoi_wr), .irq(irq));

  // read mux, registered with a clock enable on the read strobe
  always_comb begin
    if (tx_hit)       rdata_d = tx_word;
    else if (rx_hit)  rdata_d = rx_word;
    else if (err_hit) rdata_d = err_word;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int TX_CH   = 8,
  parameter int RX_CH   = 8,
  parameter int ERR_SRC = 2,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wdata,
  input logic [31:0]        rdata,
  input logic               irq,
  input logic [TX_CH-1:0]   tx_mask,
  input logic [TX_CH-1:0]   tx_masked,
  input logic [RX_CH-1:0]   rx_mask,
  input logic [RX_CH-1:0]   rx_masked,
  input logic [ERR_SRC-1:0] err_masked
);
  localparam logic [ADDR_W-1:0] A_TX_MSK = ADDR_W'('h84 >> 2);
  localparam logic [ADDR_W-1:0] A_TX_SET = ADDR_W'('h88 >> 2);
  localparam logic [ADDR_W-1:0] A_TX_CLR = ADDR_W'('h8C >> 2);
  localparam logic [ADDR_W-1:0] A_RX_SET = ADDR_W'('hA8 >> 2);
  localparam logic [ADDR_W-1:0] A_RX_CLR = ADDR_W'('hAC >> 2);
  localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'('h94 >> 2);

  logic pend;
  assign pend = (|tx_masked) | (|rx_masked) | (|err_masked);

  // R10
  eoi_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EOI && wdata == 32'd0) |=> !irq);

  // R2
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TX_SET) |=> ((tx_mask & $past(wdata[TX_CH-1:0])) == $past(wdata[TX_CH-1:0])));

  // R3
  rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_RX_CLR) |=> ((rx_mask & $past(wdata[RX_CH-1:0])) == '0));

  // R8
  tx_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_TX_SET || addr == A_TX_CLR)) |=> $stable(tx_mask));

  // R8
  rx_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_RX_SET || addr == A_RX_CLR)) |=> $stable(rx_mask));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend));

  // R6
  tx_msk_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_TX_MSK) |=> (rdata == 32'($past(tx_masked))));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .TX_CH(TX_CH), .RX_CH(RX_CH), .ERR_SRC(ERR_SRC), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .tx_mask(tx_mask),
  .tx_masked(tx_masked), .rx_mask(rx_mask), .rx_masked(rx_masked),
  .err_masked(err_masked)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tx_req;
  logic [7:0]  rx_req;
  logic [1:0]  err_req;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int compared   = 0;
  int mismatched = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
    .err_req(err_req), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] boff, input logic [31:0] d);
    wr_en = 1'b1; addr = boff[7:2]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // driver: pushes the expected word, the monitor compares it
  task automatic rd(input logic [7:0] boff, input logic [31:0] exp, input string req);
    rd_en = 1'b1; addr = boff[7:2];
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) rd_d <= rd_en;

  // monitor
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R11: actual %h expected no data", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_req = '0; rx_req = '0; err_req = '0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rdata", rdata, 32'd0);
    rd(8'h88, 32'h0, "R1 tx mask");
    rd(8'hA8, 32'h0, "R1 rx mask");
    rd(8'hB8, 32'h0, "R1 err mask");

    // R2 set only adds bits
    wr(8'h88, 32'h05);
    rd(8'h88, 32'h05, "R2 set");
    wr(8'h88, 32'h30);
    rd(8'h88, 32'h35, "R2 zeros unchanged");
    // R4 width boundary
    wr(8'hA8, 32'hFFFF_FFFF);
    rd(8'hA8, 32'h0000_00FF, "R4 rx width");
    wr(8'hB8, 32'hFFFF_FFFF);
    rd(8'hB8, 32'h0000_0003, "R4 err width");
    // R3 clear
    wr(8'hAC, 32'h0F);
    rd(8'hAC, 32'hF0, "R3 partial clear / R7 clr readback");
    wr(8'hAC, 32'hFFFF_FFFF);
    rd(8'hA8, 32'h00, "R3 clear all");
    wr(8'h8C, 32'h01);
    rd(8'h8C, 32'h34, "R3 tx clear bit0 / R7");
    rd(8'h88, 32'h34, "R7 set readback");
    idle(2);
    check("R9 irq quiet", 32'(irq), 32'd0);

    // R5 R6 status views, tx mask 0x34
    tx_req = 8'h0F;
    idle(2);
    rd(8'h80, 32'h0F, "R5 tx raw");
    rd(8'h84, 32'h04, "R6 tx masked");
    check("R9 irq from tx", 32'(irq), 32'd1);
    // R8 writes to status registers ignored
    wr(8'h80, 32'hFF);
    wr(8'h84, 32'h00);
    rd(8'h80, 32'h0F, "R8 raw unchanged");
    rd(8'h84, 32'h04, "R8 masked unchanged");
    rd(8'h88, 32'h34, "R8 mask unchanged");
    // R5 follows deassertion, R9 falls
    tx_req = 8'h0B;
    idle(2);
    rd(8'h80, 32'h0B, "R5 raw follows fall");
    check("R9 irq falls", 32'(irq), 32'd0);

    // receive group
    wr(8'hA8, 32'h0F);
    rx_req = 8'hA0;
    idle(2);
    rd(8'hA0, 32'hA0, "R5 rx raw");
    rd(8'hA4, 32'h00, "R6 rx masked none");
    check("R6 unmasked rx no irq", 32'(irq), 32'd0);
    rx_req = 8'hA5;
    idle(2);
    rd(8'hA4, 32'h05, "R6 rx masked");
    check("R9 irq from rx", 32'(irq), 32'd1);
    rx_req = 8'h00;
    idle(2);
    check("R9 irq rx gone", 32'(irq), 32'd0);

    // R4 host error bit 1
    err_req = 2'b10;
    idle(2);
    rd(8'hB0, 32'h2, "R4 host error raw");
    rd(8'hB4, 32'h2, "R4 host error masked");
    check("R9 irq from err", 32'(irq), 32'd1);

    // R10 end of interrupt with pending work
    wr(8'h94, 32'h0);
    check("R10 blank cycle", 32'(irq), 32'd0);
    @(negedge clk);
    check("R10 reassert", 32'(irq), 32'd1);
    wr(8'h94, 32'h1);
    check("R10 nonzero ignored", 32'(irq), 32'd1);
    @(negedge clk);
    check("R10 nonzero ignored 2", 32'(irq), 32'd1);
    // R10 nothing pending
    wr(8'hBC, 32'h2);
    idle(1);
    check("R9 irq err masked off", 32'(irq), 32'd0);
    wr(8'h94, 32'h0);
    check("R10 idle eoi", 32'(irq), 32'd0);
    @(negedge clk);
    check("R10 idle eoi stays low", 32'(irq), 32'd0);

    // R11 unmapped and hold
    rd(8'h00, 32'h0, "R11 unmapped");
    rd(8'h94, 32'h0, "R11 eoi reads zero");
    rd(8'hB0, 32'h2, "R11 err raw");
    idle(3);
    check("R11 hold", rdata, 32'h2);

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule